// File: doc/BRIEF.md
# Differential Lane Rotator for Layered LDPC Decoding

This block sits between a variable-message memory and a row of 27 check-node lanes. Each memory word holds 27 lanes of 6-bit soft values, one word per block column of the parity check matrix. Each access rotates a word cyclically by whole lanes, so that every lane meets the check node that the shifted identity sub-matrix assigns to it.

Decoded words go back to memory without being rotated back. The block therefore keeps a small table with one entry per column. Each entry holds the alignment that the stored word currently has. On a read it rotates only by the difference between the alignment the sub-matrix wants and the one the word already has, modulo 27.

When channel values are loaded for a new codeword, each column word is rotated by that column's shift in the final layer. This makes the first layer of every iteration see the same differential amounts. A register after the rotator holds the result for one cycle. The shift table and the memory itself stay outside the block.

Top module: `diff_rotate_net`

## Requirements
- R1: After reset, `out_valid_o` and `out_load_o` are 0 and every column alignment is 0. A first read with shift s is therefore rotated by s.
- R2: A read with `rd_req_i`=1, `rd_ok_i`=1 and `ld_i`=0 is answered one cycle later.
    - In that cycle `out_valid_o`=1 and `out_load_o`=0.
    - `out_word_o` is `word_i` rotated by (`rd_shift_i` minus the alignment of column `col_i`) mod 27.
- R3: When `rd_shift_i` is smaller than the column alignment, the rotation amount is `rd_shift_i`+27 minus the alignment. Equal values give amount 0.
- R4: A read marked as a null entry (`rd_req_i`=1, `rd_ok_i`=0) produces no output and leaves every alignment unchanged.
- R5: `wb_en_i`=1 sets the alignment of column `wb_col_i` to `wb_shift_i`. No other column changes.
- R6: `init_i`=1 loads the alignment of every column c from `init_shift_i[5c+4:5c]`.
- R7: `ld_i`=1 is answered one cycle later.
    - In that cycle `out_valid_o`=1 and `out_load_o`=1.
    - `out_word_o` is `word_i` rotated by the current alignment of column `col_i`, which is the final-layer shift.
- R8: Lane j of a word occupies bits [6j+5:6j]. Rotation by amount a puts input lane (j+a) mod 27 onto output lane j.
- R9: If `init_i` and `wb_en_i` are high in the same cycle, the initialisation wins and the write-back update is discarded.
- R10: If `ld_i` and a valid read arrive together, the load is served and the read is dropped.
- R11: A cycle with neither a load nor a valid read gives `out_valid_o`=0 on the next cycle, and `out_word_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Load all column alignments from `init_shift_i` |
| init_shift_i | input | 120 | Final-layer shift per column, 5 bits per column |
| ld_i | input | 1 | Channel-load request for column `col_i` |
| rd_req_i | input | 1 | Read request for column `col_i` |
| rd_ok_i | input | 1 | Shift-table entry is a real sub-matrix (not null) |
| col_i | input | 5 | Column addressed by a load or read |
| rd_shift_i | input | 5 | Wanted alignment from the shift table, 0 to 26 |
| word_i | input | 162 | Memory word (read) or channel word (load) |
| wb_en_i | input | 1 | A word for column `wb_col_i` is written back |
| wb_col_i | input | 5 | Column of the write-back |
| wb_shift_i | input | 5 | Alignment of the word written back |
| out_valid_o | output | 1 | Registered result is valid |
| out_load_o | output | 1 | Result comes from a channel load |
| out_word_o | output | 162 | Rotated word |

## Verification
Every load or valid read shows its rotated word exactly one clock edge after the inputs are presented. Alignment updates from write-back or initialisation affect the next request in the following cycle. The driver applies each stimulus at a falling edge, works out the answer from its own alignment model, and queues it. The monitor samples just after the next rising edge and removes one queued item per cycle. Each cycle is therefore checked against the stimulus one edge earlier, including empty cycles where the word must hold.

// File: rtl/drn_pkg.sv
package drn_pkg;
    localparam int DRN_LANES = 27;
    localparam int DRN_LW    = 6;
    localparam int DRN_COLS  = 24;
endpackage

// File: rtl/drn_modsub.sv
module drn_modsub #(
    parameter int LANES = 27,
    parameter int SW    = 5
) (
    input  logic [SW-1:0] want_i,
    input  logic [SW-1:0] have_i,
    output logic [SW-1:0] diff_o
);
    logic [SW:0] raw;
    logic [SW:0] wrapped;

    assign raw     = {1'b0, want_i} - {1'b0, have_i};
    assign wrapped = raw + (SW+1)'(LANES);
    // negative raw difference folds back into 0..LANES-1
    assign diff_o  = raw[SW] ? wrapped[SW-1:0] : raw[SW-1:0];
endmodule

// File: rtl/drn_rotator.sv
module drn_rotator #(
    parameter int LANES = 27,
    parameter int LW    = 6,
    parameter int SW    = 5,
    localparam int WW   = LANES * LW
) (
    input  logic [WW-1:0] data_i,
    input  logic [SW-1:0] amt_i,
    output logic [WW-1:0] data_o
);
    logic [SW:0][WW-1:0] stg;

    assign stg[0] = data_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int R = (1 << k) % LANES;
        if (R == 0) begin : g_pass
            assign stg[k+1] = stg[k];
        end else begin : g_rot
            // output lane j takes input lane j+R (cyclic)
            assign stg[k+1] = amt_i[k] ? {stg[k][R*LW-1:0], stg[k][WW-1:R*LW]}
                                       : stg[k];
        end
    end

    assign data_o = stg[SW];
endmodule

// File: rtl/diff_rotate_net.sv
module diff_rotate_net
    import drn_pkg::*;
#(
    parameter int LANES = DRN_LANES,
    parameter int LW    = DRN_LW,
    parameter int COLS  = DRN_COLS,
    localparam int WW   = LANES * LW,
    localparam int SW   = $clog2(LANES),
    localparam int CW   = $clog2(COLS)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               init_i,
    input  logic [COLS*SW-1:0] init_shift_i,
    input  logic               ld_i,
    input  logic               rd_req_i,
    input  logic               rd_ok_i,
    input  logic [CW-1:0]      col_i,
    input  logic [SW-1:0]      rd_shift_i,
    input  logic [WW-1:0]      word_i,
    input  logic               wb_en_i,
    input  logic [CW-1:0]      wb_col_i,
    input  logic [SW-1:0]      wb_shift_i,
    output logic               out_valid_o,
    output logic               out_load_o,
    output logic [WW-1:0]      out_word_o
);
    typedef struct packed {
        logic [COLS-1:0][SW-1:0] align;
        logic                    vld;
        logic                    ld;
        logic [WW-1:0]           word;
    } state_t;

    state_t        st_d, st_q;
    logic [SW-1:0] cur_align;
    logic [SW-1:0] diff_amt;
    logic [SW-1:0] rot_amt;
    logic [WW-1:0] rot_word;
    logic          fire;

    assign cur_align = st_q.align[col_i];

    drn_modsub #(.LANES(LANES), .SW(SW)) i_modsub (
        .want_i (rd_shift_i),
        .have_i (cur_align),
        .diff_o (diff_amt)
    );

    // a load aligns the raw channel word to the final-layer shift
    assign rot_amt = ld_i ? cur_align : diff_amt;

    drn_rotator #(.LANES(LANES), .LW(LW), .SW(SW)) i_rotator (
        .data_i (word_i),
        .amt_i  (rot_amt),
        .data_o (rot_word)
    );

    assign fire = ld_i | (rd_req_i & rd_ok_i);

    always_comb begin
        st_d     = st_q;
        st_d.vld = fire;
        st_d.ld  = ld_i;
        if (fire) begin
            st_d.word = rot_word;
        end
        if (init_i) begin
            for (int c = 0; c < COLS; c++) begin
                st_d.align[c] = init_shift_i[c*SW +: SW];
            end
        end else if (wb_en_i) begin
            st_d.align[wb_col_i] = wb_shift_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign out_load_o  = st_q.ld;
    assign out_word_o  = st_q.word;
endmodule

// File: rtl/diff_rotate_net_chk.sv
module diff_rotate_net_chk #(
    parameter int WW = 162
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          ld_i,
    input logic          rd_req_i,
    input logic          rd_ok_i,
    input logic          out_valid_o,
    input logic          out_load_o,
    input logic [WW-1:0] out_word_o
);
    // R11
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld_i && !(rd_req_i && rd_ok_i)) |=> !out_valid_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld_i && !(rd_req_i && rd_ok_i)) |=> $stable(out_word_o));

    // R4
    null_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_i && !rd_ok_i && !ld_i) |=> !out_valid_o);

    // R7
    load_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i |=> (out_valid_o && out_load_o));

    // R2
    read_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_i && rd_ok_i && !ld_i) |=> (out_valid_o && !out_load_o));
endmodule

bind diff_rotate_net diff_rotate_net_chk #(.WW(WW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_i        (ld_i),
    .rd_req_i    (rd_req_i),
    .rd_ok_i     (rd_ok_i),
    .out_valid_o (out_valid_o),
    .out_load_o  (out_load_o),
    .out_word_o  (out_word_o)
);

// File: tb/test_diff_rotate_net.sv
`timescale 1ns/1ps
module test_diff_rotate_net;
    localparam int LANES = 27;
    localparam int LW    = 6;
    localparam int COLS  = 24;
    localparam int SW    = 5;
    localparam int CW    = 5;
    localparam int WW    = LANES * LW;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               init;
    logic [COLS*SW-1:0] init_shift;
    logic               ld;
    logic               rd_req;
    logic               rd_ok;
    logic [CW-1:0]      col;
    logic [SW-1:0]      rd_shift;
    logic [WW-1:0]      word;
    logic               wb_en;
    logic [CW-1:0]      wb_col;
    logic [SW-1:0]      wb_shift;
    logic               out_valid;
    logic               out_load;
    logic [WW-1:0]      out_word;

    always #2 clk = ~clk;

    diff_rotate_net i_diff_rotate_net (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .init_i       (init),
        .init_shift_i (init_shift),
        .ld_i         (ld),
        .rd_req_i     (rd_req),
        .rd_ok_i      (rd_ok),
        .col_i        (col),
        .rd_shift_i   (rd_shift),
        .word_i       (word),
        .wb_en_i      (wb_en),
        .wb_col_i     (wb_col),
        .wb_shift_i   (wb_shift),
        .out_valid_o  (out_valid),
        .out_load_o   (out_load),
        .out_word_o   (out_word)
    );

    typedef struct {
        logic          v;
        logic          l;
        logic [WW-1:0] w;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            checks   = 0;
    int            failures = 0;
    int            am[COLS];
    logic [WW-1:0] last_w = '0;
    bit            done = 0;

    function automatic logic [WW-1:0] rotm(input logic [WW-1:0] x, input int a);
        logic [WW-1:0] r;
        for (int j = 0; j < LANES; j++) r[j*LW +: LW] = x[((j + a) % LANES)*LW +: LW];
        return r;
    endfunction

    function automatic logic [WW-1:0] pat(input int k);
        logic [WW-1:0] r;
        for (int j = 0; j < LANES; j++) r[j*LW +: LW] = 6'((j * 5 + k) & 63);
        return r;
    endfunction

    task automatic step(input bit i_init, input logic [COLS*SW-1:0] iv, input bit i_ld,
                        input bit i_rd, input bit i_ok, input int c, input int s,
                        input logic [WW-1:0] w, input bit i_wb, input int wc,
                        input int ws, input string tag);
        exp_t e;
        @(negedge clk);
        init = i_init; init_shift = iv; ld = i_ld; rd_req = i_rd; rd_ok = i_ok;
        col = CW'(c); rd_shift = SW'(s); word = w;
        wb_en = i_wb; wb_col = CW'(wc); wb_shift = SW'(ws);
        e.tag = tag;
        e.l   = i_ld;
        e.v   = i_ld | (i_rd & i_ok);
        if (i_ld)              e.w = rotm(w, am[c]);
        else if (i_rd && i_ok) e.w = rotm(w, (s - am[c] + LANES) % LANES);
        else                   e.w = '0;
        sb.push_back(e);
        if (i_init) begin
            for (int k = 0; k < COLS; k++) am[k] = int'(iv[k*SW +: SW]);
        end else if (i_wb) begin
            am[wc] = ws;
        end
    endtask

    task automatic t_rd(input int c, input int s, input logic [WW-1:0] w, input string tag);
        step(0, '0, 0, 1, 1, c, s, w, 0, 0, 0, tag);
    endtask
    task automatic t_ld(input int c, input logic [WW-1:0] w, input string tag);
        step(0, '0, 1, 0, 0, c, 0, w, 0, 0, 0, tag);
    endtask
    task automatic t_idle(input string tag);
        step(0, '0, 0, 0, 0, 0, 0, pat(7), 0, 0, 0, tag);
    endtask

    // monitor: one queued expectation per cycle, sampled after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                bit   bad;
                e = sb.pop_front();
                checks++;
                if (e.v) bad = !(out_valid === 1'b1 && out_load === e.l && out_word === e.w);
                else     bad = !(out_valid === 1'b0 && out_word === last_w);
                if (bad) begin
                    failures++;
                    $display("FAIL %s: got v=%0b l=%0b w=%h exp v=%0b l=%0b w=%h",
                             e.tag, out_valid, out_load, out_word, e.v, e.l,
                             e.v ? e.w : last_w);
                end
            end
            if (rst_n) last_w = out_word;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11: watchdog expired, got done=0 exp done=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [COLS*SW-1:0] iv1;
        logic [COLS*SW-1:0] iv2;
        rst_n = 0; init = 0; init_shift = '0; ld = 0; rd_req = 0; rd_ok = 0;
        col = '0; rd_shift = '0; word = '0; wb_en = 0; wb_col = '0; wb_shift = '0;
        for (int k = 0; k < COLS; k++) am[k] = 0;
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_load !== 1'b0) begin
            failures++;
            $display("FAIL R1: got v=%0b l=%0b exp v=0 l=0", out_valid, out_load);
        end
        rst_n = 1;

        t_rd(3, 10, pat(1), "R1 zero alignment");
        t_rd(0, 1, pat(0), "R8 lane mapping");
        t_rd(9, 26, pat(2), "R8 max amount");

        for (int k = 0; k < COLS; k++) iv1[k*SW +: SW] = SW'((k * 7 + 3) % LANES);
        step(1, iv1, 0, 0, 0, 0, 0, pat(3), 0, 0, 0, "R6 init");
        t_rd(2, 20, pat(4), "R6 init alignment");
        t_ld(4, pat(5), "R7 load col4");
        t_ld(5, pat(6), "R7 load col5");
        t_ld(6, pat(8), "R7 load col6");
        t_rd(5, 25, pat(9), "R2 positive diff");
        t_rd(5, 2, pat(10), "R3 wrap");
        t_rd(5, 11, pat(11), "R3 equal");

        step(0, '0, 0, 1, 0, 5, 0, pat(12), 0, 0, 0, "R4 null");
        t_rd(5, 11, pat(13), "R4 alignment kept");

        step(0, '0, 0, 0, 0, 0, 0, pat(14), 1, 5, 20, "R5 writeback");
        t_rd(5, 20, pat(15), "R5 updated column");
        t_rd(6, 18, pat(16), "R5 other column");

        for (int k = 0; k < COLS; k++) iv2[k*SW +: SW] = SW'(9);
        step(1, iv2, 0, 0, 0, 0, 0, pat(17), 1, 7, 1, "R9 init over wb");
        t_rd(7, 9, pat(18), "R9 wb discarded");

        step(0, '0, 1, 1, 1, 8, 3, pat(19), 0, 0, 0, "R10 load over read");
        t_idle("R11 idle");
        t_idle("R11 idle hold");

        for (int n = 0; n < 40; n++) begin
            int c;
            int s;
            logic [WW-1:0] w;
            c = int'($urandom % COLS);
            s = int'($urandom % LANES);
            for (int j = 0; j < LANES; j++) w[j*LW +: LW] = 6'($urandom);
            if (n % 5 == 4) step(0, '0, 0, 1, 1, c, s, w, 1, (c + 3) % COLS, s, "R2 R5 mixed");
            else            t_rd(c, s, w, "R2 random");
        end
        t_idle("R11 tail");
        t_idle("R11 tail");

        while (sb.size() > 0) @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule